// File: doc/BRIEF.md
# Program Counter and Return Stack Unit

This unit sequences instruction fetch for a small 8-bit core with 13-bit instruction words and a 1024-word program space. It holds a 10-bit fetch address. Each cycle the address either steps forward by one or is replaced by a new value. A new value can come from a jump or call target, a popped return address, an interrupt vector, or a write to the low-byte program counter register. The bits above the low byte are taken from a separate high-bits buffer register.

Each change of flow costs two cycles. In the cycle after the change, `flush` is high. During that bubble cycle the new address is being fetched, the address holds, and every request is ignored. Return addresses go to a circular stack. When it is full, a push overwrites the oldest entry. A pop from an empty stack returns whatever sits in the slot below the pointer, and no error is flagged.

Top module: `pcseq_unit`

## Requirements
- R1: While reset is low and in the first cycle after it, `fetch_addr` is 3FFh, `flush` is 0 and `hib_rdata` is 00h.
- R2: In a cycle with no accepted request, the next `fetch_addr` is the current one plus one, and 3FFh wraps to 000h.
- R3: A jump loads the 10-bit `tgt` into `fetch_addr` at the next edge. `flush` is then high for exactly one cycle. During that cycle `fetch_addr` holds and all requests are ignored, including writes to the high-bits buffer.
- R4: A call loads `tgt` and pushes `fetch_addr`+1 (wrapped to 10 bits). A return loads the most recently pushed address that has not yet been popped.
- R5: The stack has 5 slots used circularly. A sixth push overwrites the oldest entry. Popping past the last valid entry returns older slot contents modulo 5 (zeros after reset), and the pops continue without any fault.
- R6: An interrupt entry loads 008h when `irq_sw`=0 and 002h when `irq_sw`=1. It pushes the current `fetch_addr`, which is the instruction it preempts. `gie_clr` is high in that same cycle only.
- R7: When several requests are present in one non-flush cycle, exactly one is taken. The priority is interrupt, then return, then call, then jump, then low-byte write.
- R8: A low-byte write loads {buffer[1:0], `pcl_wdata`}. The buffer keeps only 2 bits and reads back zero-extended on `hib_rdata`. A buffer write in the same cycle as a low-byte write takes effect afterwards, so the old buffer value is used.
- R9: `pcl_rdata` always equals the low 8 bits of `fetch_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Interrupt entry request |
| irq_sw | input | 1 | Interrupt type: 1 software, 0 hardware |
| ret_req | input | 1 | Return from subroutine or interrupt |
| call_req | input | 1 | Subroutine call to `tgt` |
| jmp_req | input | 1 | Jump to `tgt` |
| tgt | input | 10 | Full target address for jump and call |
| pcl_we | input | 1 | Write to low-byte counter register |
| pcl_wdata | input | 8 | Data for low-byte write |
| hib_we | input | 1 | Write to high-bits buffer register |
| hib_wdata | input | 8 | Data for buffer write (low 2 bits kept) |
| fetch_addr | output | 10 | Current program fetch address |
| flush | output | 1 | Bubble cycle following a flow change |
| gie_clr | output | 1 | Pulse that clears the global interrupt enable |
| pcl_rdata | output | 8 | Low-byte counter register readback |
| hib_rdata | output | 8 | High-bits buffer readback |

## Verification
The sharpest collision is an interrupt entry that falls in the same cycle as a call, a return or a low-byte write. The interrupt must win and push the preempted address, not the call's successor. The bench provokes this by raising `irq_req` together with `call_req`, and also by pairing return with call, call with jump, jump with a low-byte write, and a buffer write with a low-byte write. A behavioural model with a plain integer stack predicts the next address and the stack contents. That model then judges the later returns, and those returns reveal whether the losing request left any trace.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
   // Source selected for the next fetch address
   typedef enum logic [2:0] {
      NX_INC  = 3'd0,
      NX_HOLD = 3'd1,
      NX_IRQ  = 3'd2,
      NX_RET  = 3'd3,
      NX_CALL = 3'd4,
      NX_JMP  = 3'd5,
      NX_PCL  = 3'd6
   } nx_sel_e;
endpackage

// File: rtl/pcseq_arb.sv
module pcseq_arb
   import pcseq_pkg::*;
(
   input  logic    hold,
   input  logic    irq,
   input  logic    ret,
   input  logic    call,
   input  logic    jmp,
   input  logic    pcl,
   output nx_sel_e sel
);
   // Fixed priority; the bubble cycle masks every request (R3, R7)
   always_comb begin
      if (hold)      sel = NX_HOLD;
      else if (irq)  sel = NX_IRQ;
      else if (ret)  sel = NX_RET;
      else if (call) sel = NX_CALL;
      else if (jmp)  sel = NX_JMP;
      else if (pcl)  sel = NX_PCL;
      else           sel = NX_INC;
   end
endmodule

// File: rtl/pcseq_hibuf.sv
module pcseq_hibuf #(
   parameter int DATA_W = 8,
   parameter int HI_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [HI_W-1:0]   q,
   output logic [DATA_W-1:0] rdata
);
   initial begin
      if (HI_W < 1 || HI_W >= DATA_W)
         $fatal(1, "pcseq_hibuf: HI_W must lie in 1..DATA_W-1");
   end

   logic unused_hi_bits;
   assign unused_hi_bits = ^wdata[DATA_W-1:HI_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (we)  q <= wdata[HI_W-1:0];
   end

   assign rdata = DATA_W'(q);

   // R8: the buffer changes only on a write
   a_r8_buf_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));
endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
   parameter int W     = 10,
   parameter int DEPTH = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] push_data,
   output logic [W-1:0] top
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit POW2  = (DEPTH == (1 << PTR_W));

   initial begin
      if (DEPTH < 2) $fatal(1, "pcseq_stack: DEPTH must be at least 2");
      if (W < 1)     $fatal(1, "pcseq_stack: W must be positive");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] ptr, ptr_inc, ptr_dec;

   generate
      if (POW2) begin : g_wrap_natural
         assign ptr_inc = ptr + 1'b1;
         assign ptr_dec = ptr - 1'b1;
      end else begin : g_wrap_compare
         assign ptr_inc = (ptr == PTR_W'(DEPTH-1)) ? '0 : ptr + 1'b1;
         assign ptr_dec = (ptr == '0) ? PTR_W'(DEPTH-1) : ptr - 1'b1;
      end
   endgenerate

   // Circular: no full or empty tracking (R5)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (push) begin
         mem[ptr] <= push_data;
         ptr      <= ptr_inc;
      end else if (pop) begin
         ptr <= ptr_dec;
      end
   end

   assign top = mem[ptr_dec];

   a_r4_push_on_top: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> top == $past(push_data));
   a_r5_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ptr) < DEPTH);
   a_r5_pop_moves_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push) |=> ptr == $past(ptr_dec));
endmodule

// File: rtl/pcseq_unit.sv
module pcseq_unit
   import pcseq_pkg::*;
#(
   parameter int              PC_W      = 10,
   parameter int              DATA_W    = 8,
   parameter int              STK_DEPTH = 5,
   parameter logic [PC_W-1:0] RESET_VEC = '1,
   parameter logic [PC_W-1:0] HW_VEC    = PC_W'(8),
   parameter logic [PC_W-1:0] SW_VEC    = PC_W'(2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req,
   input  logic              irq_sw,
   input  logic              ret_req,
   input  logic              call_req,
   input  logic              jmp_req,
   input  logic [PC_W-1:0]   tgt,
   input  logic              pcl_we,
   input  logic [DATA_W-1:0] pcl_wdata,
   input  logic              hib_we,
   input  logic [DATA_W-1:0] hib_wdata,
   output logic [PC_W-1:0]   fetch_addr,
   output logic              flush,
   output logic              gie_clr,
   output logic [DATA_W-1:0] pcl_rdata,
   output logic [DATA_W-1:0] hib_rdata
);
   localparam int HI_W = PC_W - DATA_W;

   initial begin
      if (PC_W <= DATA_W) $fatal(1, "pcseq_unit: PC_W must exceed DATA_W");
   end

   nx_sel_e         sel;
   logic [PC_W-1:0] pc_q, pc_nxt, pc_plus1, stk_top, push_data;
   logic            flush_q, push, pop;
   logic [HI_W-1:0] hib_q;

   pcseq_arb u_arb (
      .hold (flush_q),
      .irq  (irq_req),
      .ret  (ret_req),
      .call (call_req),
      .jmp  (jmp_req),
      .pcl  (pcl_we),
      .sel  (sel)
   );

   pcseq_hibuf #(.DATA_W(DATA_W), .HI_W(HI_W)) u_hibuf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (hib_we && !flush_q),
      .wdata (hib_wdata),
      .q     (hib_q),
      .rdata (hib_rdata)
   );

   pcseq_stack #(.W(PC_W), .DEPTH(STK_DEPTH)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .pop       (pop),
      .push_data (push_data),
      .top       (stk_top)
   );

   assign pc_plus1 = pc_q + 1'b1;

   always_comb begin
      pc_nxt    = pc_plus1;
      push      = 1'b0;
      pop       = 1'b0;
      push_data = pc_plus1;
      unique case (sel)
         NX_HOLD: pc_nxt = pc_q;
         NX_IRQ: begin
            pc_nxt    = irq_sw ? SW_VEC : HW_VEC;
            push      = 1'b1;
            push_data = pc_q;           // preempted instruction resumes
         end
         NX_RET: begin
            pc_nxt = stk_top;
            pop    = 1'b1;
         end
         NX_CALL: begin
            pc_nxt = tgt;
            push   = 1'b1;
         end
         NX_JMP:  pc_nxt = tgt;
         NX_PCL:  pc_nxt = {hib_q, pcl_wdata};
         default: pc_nxt = pc_plus1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q    <= RESET_VEC;
         flush_q <= 1'b0;
      end else begin
         pc_q    <= pc_nxt;
         flush_q <= (sel != NX_INC) && (sel != NX_HOLD);
      end
   end

   assign fetch_addr = pc_q;
   assign flush      = flush_q;
   assign gie_clr    = (sel == NX_IRQ);
   assign pcl_rdata  = pc_q[DATA_W-1:0];

   a_r3_bubble_holds: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> ($stable(fetch_addr) && !flush));
   a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && !irq_req && !ret_req && !call_req && !jmp_req && !pcl_we)
      |=> (fetch_addr == PC_W'($past(fetch_addr) + 1'b1)) && !flush);
   a_r6_vector_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !flush) |=> fetch_addr == ($past(irq_sw) ? SW_VEC : HW_VEC));
   a_r6_gie_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      gie_clr |-> (!flush && irq_req));
   a_r3_jump_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (jmp_req && !flush && !irq_req && !ret_req && !call_req)
      |=> (fetch_addr == $past(tgt)) && flush);
endmodule

// File: tb/pcseq_unit_tb.sv
`timescale 1ns/1ps
module pcseq_unit_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       irq_req = 0, irq_sw = 0, ret_req = 0, call_req = 0, jmp_req = 0;
   logic [9:0] tgt = '0;
   logic       pcl_we = 0, hib_we = 0;
   logic [7:0] pcl_wdata = '0, hib_wdata = '0;
   logic [9:0] fetch_addr;
   logic       flush, gie_clr;
   logic [7:0] pcl_rdata, hib_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // Behavioural reference state
   int m_pc, m_flush, m_hib, m_sp;
   int m_stk[5];

   always #2 clk = ~clk;

   pcseq_unit u_dut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_sw(irq_sw),
      .ret_req(ret_req), .call_req(call_req), .jmp_req(jmp_req), .tgt(tgt),
      .pcl_we(pcl_we), .pcl_wdata(pcl_wdata), .hib_we(hib_we),
      .hib_wdata(hib_wdata), .fetch_addr(fetch_addr), .flush(flush),
      .gie_clr(gie_clr), .pcl_rdata(pcl_rdata), .hib_rdata(hib_rdata)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic push(input int v);
      m_stk[m_sp] = v;
      m_sp = (m_sp + 1) % 5;
   endtask

   function automatic int pop();
      m_sp = (m_sp + 4) % 5;
      return m_stk[m_sp];
   endfunction

   // Compare, advance model, take one clock; inputs return to idle
   task automatic cyc(input string tag);
      int exp_gie;
      int old_hib;
      #1;
      exp_gie = (m_flush == 0 && irq_req) ? 1 : 0;
      check(tag, "fetch_addr", int'(fetch_addr), m_pc);
      check(tag, "flush", int'(flush), m_flush);
      check(tag, "gie_clr", int'(gie_clr), exp_gie);
      check("R9", "pcl_rdata", int'(pcl_rdata), m_pc % 256);
      check("R8", "hib_rdata", int'(hib_rdata), m_hib);
      old_hib = m_hib;
      if (m_flush != 0) begin
         m_flush = 0;
      end else begin
         m_flush = 1;
         if (irq_req) begin push(m_pc); m_pc = irq_sw ? 2 : 8; end
         else if (ret_req) m_pc = pop();
         else if (call_req) begin push((m_pc + 1) % 1024); m_pc = int'(tgt); end
         else if (jmp_req) m_pc = int'(tgt);
         else if (pcl_we) m_pc = old_hib * 256 + int'(pcl_wdata);
         else begin m_pc = (m_pc + 1) % 1024; m_flush = 0; end
         if (hib_we) m_hib = int'(hib_wdata) % 4;
      end
      @(posedge clk);
      @(negedge clk);
      irq_req = 0; irq_sw = 0; ret_req = 0; call_req = 0; jmp_req = 0;
      pcl_we = 0; hib_we = 0; tgt = '0; pcl_wdata = '0; hib_wdata = '0;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      m_pc = 1023; m_flush = 0; m_hib = 0; m_sp = 0;
      for (int i = 0; i < 5; i++) m_stk[i] = 0;
      @(negedge clk); @(negedge clk);
      #1;
      check("R1", "reset fetch_addr", int'(fetch_addr), 1023);
      check("R1", "reset flush", int'(flush), 0);
      check("R1", "reset hib_rdata", int'(hib_rdata), 0);
      @(negedge clk);
      rst_n = 1;
      cyc("R1");                                  // 3FF -> 000 wrap
      for (int i = 0; i < 3; i++) cyc("R2");
      // R3: jump, then a call offered in the bubble is ignored
      jmp_req = 1; tgt = 10'h3FD; cyc("R3");
      call_req = 1; tgt = 10'h100; hib_we = 1; hib_wdata = 8'h02; cyc("R3");
      for (int i = 0; i < 4; i++) cyc("R2");
      // R4/R5: seven nested calls overwrite the two oldest slots
      for (int i = 0; i < 7; i++) begin
         call_req = 1; tgt = 10'(10'h040 + i * 8); cyc("R4");
         cyc("R4");
      end
      for (int i = 0; i < 8; i++) begin
         ret_req = 1; cyc("R5");
         cyc("R5");
      end
      // R6: hardware then software interrupt entry
      irq_req = 1; cyc("R6"); cyc("R6"); cyc("R6");
      irq_req = 1; irq_sw = 1; call_req = 1; tgt = 10'h2AA; cyc("R7");
      cyc("R7");
      ret_req = 1; cyc("R6"); cyc("R6");
      ret_req = 1; cyc("R6"); cyc("R6");
      // R7: collisions resolved by priority
      ret_req = 1; call_req = 1; tgt = 10'h155; cyc("R7"); cyc("R7");
      call_req = 1; jmp_req = 1; tgt = 10'h0F0; cyc("R7"); cyc("R7");
      ret_req = 1; cyc("R4"); cyc("R4");
      jmp_req = 1; pcl_we = 1; pcl_wdata = 8'h77; tgt = 10'h222; cyc("R7"); cyc("R7");
      irq_req = 1; pcl_we = 1; pcl_wdata = 8'h11; cyc("R7"); cyc("R7");
      // R8: buffer width, readback and same-cycle ordering
      hib_we = 1; hib_wdata = 8'hFF; cyc("R8");
      cyc("R8");
      pcl_we = 1; pcl_wdata = 8'h34; cyc("R8"); cyc("R8");
      hib_we = 1; hib_wdata = 8'h01; pcl_we = 1; pcl_wdata = 8'h80; cyc("R8"); cyc("R8");
      pcl_we = 1; pcl_wdata = 8'hFE; cyc("R8"); cyc("R8");
      for (int i = 0; i < 4; i++) cyc("R9");
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule